// File: doc/BRIEF.md
# Bus Wait-State Generator with Strobe Split

This block sits between a fast processor bus and a slow parallel peripheral. When the address decoder asserts the peripheral's chip-select, the block drops the processor's ready line. The processor then freezes in its current bus cycle while a counter runs through a chosen number of bus cycles. After the last stalled cycle, ready returns high and the access finishes at the following clock edge. Each stalled cycle gives the peripheral one more full bus period on top of the short half-cycle access window. At an 8 MHz bus, one extra cycle stretches a 42 ns window to about 167 ns, and each further cycle adds another 125 ns.

The block also serves peripherals that want separate read and write strobes. It turns the host's single direction line into an active-low output-enable and an active-low write-enable. Each strobe is valid only during the second clock phase of a selected cycle. The host address and write data are captured in the first cycle of an access and held on the peripheral side until the access ends. This covers the write-data hold time, which at the host is only a few nanoseconds after the window closes. The block never drives the bus-enable line: stalling by ready does not take the bus away from the processor.

The stall length is set by an input that is sampled only when an access starts. A value of zero makes the block a plain pass-through with no stall. The bus clock drives the block's clock, so one clock equals one bus cycle, and `phase2` marks the second half of each cycle.

Top module: `wsgen_top`

## Requirements
- R1: While reset is held, and afterwards while `csN` is high, `ready` is 1 and `periphOeN` and `periphWeN` are both 1.
- R2: With `waitCycles` = N > 0 at the start of an access, `ready` is 0 in exactly N consecutive bus cycles, beginning with the access's first cycle. It is 1 in cycle N+1, which completes the access.
- R3: With `waitCycles` = 0 at the start of an access, `ready` stays 1 and the access completes in its first cycle.
- R4: `ready` is 0 only while `csN` is 0. If `csN` rises in the middle of a stall, the stall is abandoned, and the next access starts a complete stall of its own length.
- R5: If `csN` stays 0 across the edge that completes an access, the next cycle starts a new access with its own full stall.
- R6: `periphOeN` is 0 only when `csN` = 0, `rdWr` = 1 (read) and `phase2` = 1. This holds in every cycle of a read, including the stalled ones.
- R7: `periphWeN` is 0 only when `csN` = 0, `rdWr` = 0 (write) and `phase2` = 1. `periphOeN` and `periphWeN` are never 0 together.
- R8: Throughout an access, `periphAddr` and `periphWrData` show the host address and data seen in the access's first cycle, even if the host lines change afterwards.
- R9: A change of `waitCycles` after the first cycle of an access has no effect on that access's stall length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one period per bus cycle |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Decoded peripheral chip-select, active low |
| rdWr | input | 1 | Host direction, 1 = read, 0 = write |
| phase2 | input | 1 | High during the second half of the bus cycle |
| waitCycles | input | CNT_W | Stall length in bus cycles, sampled at access start |
| hostAddr | input | ADDR_W | Host register-select address |
| hostWrData | input | DATA_W | Host write data |
| ready | output | 1 | Processor ready, 0 stalls the current cycle |
| periphAddr | output | ADDR_W | Address held for the peripheral |
| periphWrData | output | DATA_W | Write data held for the peripheral |
| periphOeN | output | 1 | Peripheral output-enable, active low |
| periphWeN | output | 1 | Peripheral write-enable, active low |

## Verification
The bench builds the block with its default widths: a 4-bit wait count, a 5-bit address and 8-bit data. With these widths the largest stall, 15 cycles, is reachable in a short run, so the bench exercises both ends of the counter next to the zero-wait pass-through. The 5-bit address and 8-bit data are wide enough to invert every bit after the first cycle, so any leak of live host values onto the held peripheral lines shows up.

// File: rtl/wsgen_pkg.sv
package wsgen_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic firstCycle;  // first cycle of an access: pass through and capture
    logic rdAccess;    // selected read
    logic wrAccess;    // selected write
  } wsStrobes_t;

endpackage

// File: rtl/wsgen_ctrl.sv
module wsgen_ctrl
  import wsgen_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdWr,
  input  logic [CNT_W-1:0] waitCycles,
  output logic             ready,
  output wsStrobes_t       strb
);

  localparam logic [CNT_W-1:0] ZERO_CNT = '0;

  logic             sel;
  logic             busy;    // access is past its first cycle and still stalled or completing
  logic [CNT_W-1:0] remain;  // stalled cycles left after the current one
  logic             holdLow;

  assign sel = ~csN;

  // First cycle: stall if a non-zero count is requested.
  // Later cycles: stall until the remaining count reaches zero.
  assign holdLow = busy ? (remain != ZERO_CNT) : (waitCycles != ZERO_CNT);
  assign ready   = ~(sel & holdLow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= ZERO_CNT;
    end else if (!sel) begin
      busy   <= 1'b0;
      remain <= ZERO_CNT;
    end else if (!busy) begin
      if (waitCycles != ZERO_CNT) begin
        busy   <= 1'b1;
        remain <= waitCycles - 1'b1;
      end
    end else if (remain == ZERO_CNT) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end

  always_comb begin
    strb.firstCycle = sel & ~busy;
    strb.rdAccess   = sel & rdWr;
    strb.wrAccess   = sel & ~rdWr;
  end

endmodule

// File: rtl/wsgen_dp.sv
module wsgen_dp
  import wsgen_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wsStrobes_t        strb,
  input  logic              phase2,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [ADDR_W-1:0] periphAddr,
  output logic [DATA_W-1:0] periphWrData,
  output logic              periphOeN,
  output logic              periphWeN
);

  logic [ADDR_W-1:0] heldAddr;
  logic [DATA_W-1:0] heldData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldData <= '0;
    end else if (strb.firstCycle) begin
      heldAddr <= hostAddr;
      heldData <= hostWrData;
    end
  end

  assign periphAddr   = strb.firstCycle ? hostAddr   : heldAddr;
  assign periphWrData = strb.firstCycle ? hostWrData : heldData;

  assign periphOeN = ~(strb.rdAccess & phase2);
  assign periphWeN = ~(strb.wrAccess & phase2);

endmodule

// File: rtl/wsgen_top.sv
module wsgen_top
  import wsgen_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdWr,
  input  logic              phase2,
  input  logic [CNT_W-1:0]  waitCycles,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic              ready,
  output logic [ADDR_W-1:0] periphAddr,
  output logic [DATA_W-1:0] periphWrData,
  output logic              periphOeN,
  output logic              periphWeN
);

  wsStrobes_t strb;

  wsgen_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .rdWr       (rdWr),
    .waitCycles (waitCycles),
    .ready      (ready),
    .strb       (strb)
  );

  wsgen_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .phase2       (phase2),
    .hostAddr     (hostAddr),
    .hostWrData   (hostWrData),
    .periphAddr   (periphAddr),
    .periphWrData (periphWrData),
    .periphOeN    (periphOeN),
    .periphWeN    (periphWeN)
  );

endmodule

// File: rtl/wsgen_chk.sv
module wsgen_chk #(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdWr,
  input logic [CNT_W-1:0]  waitCycles,
  input logic              ready,
  input logic [ADDR_W-1:0] periphAddr,
  input logic              periphOeN,
  input logic              periphWeN
);

  localparam int MAX_STALL = (1 << CNT_W) - 1;

  logic [CNT_W:0] stallRun;

  always_ff @(posedge clk) begin
    if (!rstN)                stallRun <= '0;
    else if (!csN && !ready)  stallRun <= stallRun + 1'b1;
    else                      stallRun <= '0;
  end

  // R4
  ready_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> ready);

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!periphOeN && !periphWeN));

  // R6
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periphOeN |-> (!csN && rdWr));

  // R7
  we_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periphWeN |-> (!csN && !rdWr));

  // R5
  fresh_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && ready) |=> (csN || waitCycles == '0 || !ready));

  // R3
  zero_wait_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && waitCycles == '0 && $past(csN || ready)) |-> ready);

  // R8
  addr_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !ready) |=> (csN || $stable(periphAddr)));

  // R2
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(stallRun) <= MAX_STALL);

endmodule

bind wsgen_top wsgen_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .rdWr       (rdWr),
  .waitCycles (waitCycles),
  .ready      (ready),
  .periphAddr (periphAddr),
  .periphOeN  (periphOeN),
  .periphWeN  (periphWeN)
);

// File: tb/wsgen_tb.sv
`timescale 1ns/100ps
module wsgen_top_tb_top;

  localparam int CNT_W  = 4;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              csN;
  logic              rdWr;
  logic              phase2;
  logic [CNT_W-1:0]  waitCycles;
  logic [ADDR_W-1:0] hostAddr;
  logic [DATA_W-1:0] hostWrData;
  logic              ready;
  logic [ADDR_W-1:0] periphAddr;
  logic [DATA_W-1:0] periphWrData;
  logic              periphOeN;
  logic              periphWeN;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wsgen_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWr(rdWr), .phase2(phase2),
    .waitCycles(waitCycles), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .ready(ready), .periphAddr(periphAddr), .periphWrData(periphWrData),
    .periphOeN(periphOeN), .periphWeN(periphWeN)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One bus cycle. Inputs are set 0.5 ns after a rising edge; returns at the
  // same point of the next cycle. Phase 1 and phase 2 values are sampled mid-phase.
  logic s1Oe, s1We, s2Rdy, s2Oe, s2We;
  logic [ADDR_W-1:0] s2Addr;
  logic [DATA_W-1:0] s2Data;

  task automatic busCycle();
    phase2 = 1'b0;
    #1;
    s1Oe = periphOeN; s1We = periphWeN;
    #0.5 phase2 = 1'b1;
    #1;
    s2Rdy = ready; s2Oe = periphOeN; s2We = periphWeN;
    s2Addr = periphAddr; s2Data = periphWrData;
    @(posedge clk);
    #0.5;
  endtask

  // Runs one access and checks stall length, strobes and held values.
  task automatic access(input int n, input bit isRead, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input bit scramble,
                        input int cfgAfter, input bit keepCs, input string tag);
    int stalls = 0;
    csN = 1'b0; rdWr = isRead; hostAddr = a; hostWrData = d;
    waitCycles = CNT_W'(n);
    for (int cyc = 0; cyc < 40; cyc++) begin
      busCycle();
      check(s1Oe && s1We, "R6", "strobe in phase 1", {s1Oe, s1We}, 3);
      if (isRead)
        check(!s2Oe && s2We, "R6", "read strobes in phase 2", {s2Oe, s2We}, 1);
      else
        check(s2Oe && !s2We, "R7", "write strobes in phase 2", {s2Oe, s2We}, 2);
      check(s2Addr == a, "R8", "held address", s2Addr, a);
      if (!isRead)
        check(s2Data == d, "R8", "held write data", s2Data, d);
      if (cyc == 0) begin
        if (scramble) begin hostAddr = ~a; hostWrData = ~d; end
        waitCycles = CNT_W'(cfgAfter);
      end
      if (s2Rdy) break;
      stalls++;
    end
    check(stalls == n, tag, "stall cycles", stalls, n);
    if (!keepCs) csN = 1'b1;
  endtask

  task automatic idleCheck(input string tag);
    csN = 1'b1;
    busCycle();
    check(s2Rdy === 1'b1, tag, "ready while idle", s2Rdy, 1);
    check(s2Oe === 1'b1 && s2We === 1'b1, tag, "strobes while idle", {s2Oe, s2We}, 3);
  endtask

  task automatic testReset();
    // R1: during reset and just after
    #1;
    check(ready === 1'b1 && periphOeN === 1'b1 && periphWeN === 1'b1, "R1",
          "outputs in reset", {ready, periphOeN, periphWeN}, 7);
    @(posedge clk); #0.5 rstN = 1'b1;
    idleCheck("R1");
  endtask

  task automatic testStallLengths();
    // R2: several counts, including the largest
    access(1, 1'b1, 5'h03, 8'h11, 1'b0, 1, 1'b0, "R2");
    idleCheck("R4");
    access(3, 1'b0, 5'h1C, 8'hA5, 1'b0, 3, 1'b0, "R2");
    access(15, 1'b1, 5'h0A, 8'h00, 1'b0, 15, 1'b0, "R2");
    access(15, 1'b0, 5'h15, 8'h5A, 1'b0, 15, 1'b0, "R2");
  endtask

  task automatic testZeroWait();
    // R3: pass-through, both directions, back to back
    access(0, 1'b1, 5'h01, 8'h00, 1'b0, 0, 1'b1, "R3");
    access(0, 1'b0, 5'h02, 8'h77, 1'b0, 0, 1'b0, "R3");
  endtask

  task automatic testBackToBack();
    // R5: chip-select held across completion
    access(2, 1'b0, 5'h04, 8'hC3, 1'b0, 2, 1'b1, "R5");
    access(2, 1'b1, 5'h05, 8'h00, 1'b0, 2, 1'b1, "R5");
    access(1, 1'b0, 5'h06, 8'h3C, 1'b0, 1, 1'b0, "R5");
  endtask

  task automatic testAbort();
    // R4: drop chip-select mid-stall
    csN = 1'b0; rdWr = 1'b1; hostAddr = 5'h07; waitCycles = 4'd4;
    busCycle();
    check(s2Rdy === 1'b0, "R4", "stall before abort", s2Rdy, 0);
    busCycle();
    check(s2Rdy === 1'b0, "R4", "stall before abort", s2Rdy, 0);
    idleCheck("R4");
    access(4, 1'b1, 5'h08, 8'h00, 1'b0, 4, 1'b0, "R4");
  endtask

  task automatic testHold();
    // R8: host lines change after the first cycle
    access(5, 1'b0, 5'h13, 8'h96, 1'b1, 5, 1'b0, "R8");
    access(2, 1'b1, 5'h0F, 8'h00, 1'b1, 2, 1'b0, "R8");
  endtask

  task automatic testCfgChange();
    // R9: wait count changed mid-access
    access(3, 1'b0, 5'h09, 8'h42, 1'b0, 12, 1'b0, "R9");
    access(6, 1'b1, 5'h0B, 8'h00, 1'b0, 0, 1'b0, "R9");
  endtask

  initial begin
    rstN = 1'b0; csN = 1'b1; rdWr = 1'b1; phase2 = 1'b0;
    waitCycles = '0; hostAddr = '0; hostWrData = '0;
    @(posedge clk); @(posedge clk);
    testReset();
    testStallLengths();
    testZeroWait();
    testBackToBack();
    testAbort();
    testHold();
    testCfgChange();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule